// File: doc/BRIEF.md
# Two-Stage Configuration Register Bank

This block holds the working configuration of a larger power-control design. Each configuration entry has two stages. The front stage (A) takes every incoming write. The back stage (B) drives the functional logic through `cfg_out`. Two sources can write:

- a plain address/data port, which stands in for the management-bus slave;
- a separate load port, used by the engine that reloads settings from non-volatile memory.

An update-control word sits at address `NUM_REGS` and sets how writes reach the back stage. In pass-through mode a write lands in both stages at the same clock edge. In staged mode a write lands only in the front stage. The back stage then waits for a commit, which is a one-cycle pulse that the block makes itself. The pulse copies every front stage into its back stage at the same edge. This lets software or the reload engine prepare a complete new setup and switch to it atomically.

The same control word holds an erase-enable flag. The flag gates page-erase commands on their way to the non-volatile store. When the flag is clear, a requested erase never reaches the store. When the flag is set, the erase passes on, and the store fills the addressed page with ones.

Top module: `cfg_dual_bank`

## Requirements
- R1: While `rst_n` is low at a clock edge, both stages of every entry and the control word are cleared to 0, and `commit_pulse` is 0.
- R2: With control bit 0 set to 1 (pass-through), a write to entry *i* appears on `cfg_out[i*DATA_W +: DATA_W]` right after the write edge.
- R3: With control bit 0 at 0 (staged), a write to entry *i* changes only the front stage: reading address *i* returns the new value, and `cfg_out` keeps its old value.
- R4: A bus write of 1 to control bit 1 at address `NUM_REGS` raises `commit_pulse` for exactly the one cycle after the write. At the end of that cycle every back stage takes its front stage value.
- R5: If a staged write meets a commit pulse in the same cycle, the back stage takes the front value from before that write, and the front stage takes the new data.
- R6: `erase_req_out` equals `erase_req_in` while control bit 2 is 1, and is 0 while bit 2 is 0. `erase_page_out` always follows `erase_page_in`.
- R7: Loads on the reload port obey the same mode as bus writes. In staged mode they change only the front stage until a commit.
- R8: When the reload port and the bus write in the same cycle, the reload is applied and the bus write is dropped, including a bus write to the control word.
- R9: A write to an address above `NUM_REGS` changes no stage and no control bit. A reload aimed at address `NUM_REGS` or above is ignored.
- R10: Reading address `NUM_REGS` returns bit 0 and bit 2 as last written, and returns 0 for bit 1 and all other bits. Reading an unused address returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_wr_en | input | 1 | Bus write strobe |
| bus_addr | input | ADDR_W | Bus write address; `NUM_REGS` selects the control word |
| bus_wdata | input | DATA_W | Bus write data |
| bus_rd_addr | input | ADDR_W | Read address |
| bus_rdata | output | DATA_W | Front stage of the addressed entry, or the control word |
| nv_ld_en | input | 1 | Reload strobe from the non-volatile engine |
| nv_ld_addr | input | ADDR_W | Reload entry index |
| nv_ld_data | input | DATA_W | Reload data |
| erase_req_in | input | 1 | Page-erase request |
| erase_page_in | input | PAGE_W | Page to erase |
| erase_req_out | output | 1 | Gated erase request toward the store |
| erase_page_out | output | PAGE_W | Page toward the store |
| commit_pulse | output | 1 | One-cycle commit strobe |
| cfg_out | output | NUM_REGS*DATA_W | Back stages, entry *i* at bits `i*DATA_W +: DATA_W` |

## Verification
The commit pulse and a staged write can meet in one cycle, whether the write comes from the bus or from the reload port. A directed case writes an entry, commits it, and rewrites the same entry during the pulse cycle. It then expects `cfg_out` to show the older value while the readback shows the newer one. A later commit must then move the newer value across. Random stimulus often places a second commit command, a pass-through switch or a reload right next to a pulse. Every cycle is compared against a bench model that applies the commit to the old front values before it applies any write.

// File: rtl/cfg_dual_pkg.sv
// Package: shared constants and types for the two-stage configuration bank.
// Assumes the control word is at least 3 bits wide.
package cfg_dual_pkg;
    localparam int CTL_PASS_BIT   = 0;  // 1 = writes reach both stages
    localparam int CTL_COMMIT_BIT = 1;  // write 1 = one-cycle commit
    localparam int CTL_ERASE_BIT  = 2;  // 1 = page erase allowed

    typedef struct packed {
        logic erase_en;
        logic pass;
    } ctl_state_t;

    typedef enum logic [1:0] {
        WSRC_NONE = 2'd0,
        WSRC_BUS  = 2'd1,
        WSRC_NV   = 2'd2
    } wr_src_e;
endpackage

// File: rtl/cfg_write_arb.sv
// Module: cfg_write_arb
// Merges the bus port and the reload port into one write request.
// The reload port has priority, and a losing bus write is dropped.
// Decodes the merged address into an entry write, a control write, or
// nothing (out-of-range addresses).
// Assumes ADDR_W can represent NUM_REGS.
module cfg_write_arb
    import cfg_dual_pkg::*;
#(
    parameter int NUM_REGS = 16,
    parameter int DATA_W   = 8,
    parameter int ADDR_W   = 5
) (
    input  logic              bus_wr_en,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              nv_ld_en,
    input  logic [ADDR_W-1:0] nv_ld_addr,
    input  logic [DATA_W-1:0] nv_ld_data,
    output wr_src_e           src_o,
    output logic              ent_wr_o,
    output logic [ADDR_W-1:0] ent_idx_o,
    output logic [DATA_W-1:0] ent_data_o,
    output logic              ctl_wr_o,
    output logic [DATA_W-1:0] ctl_data_o
);
    localparam logic [ADDR_W-1:0] CTL_ADDR = ADDR_W'(NUM_REGS);

    // Pick the write source: the reload port wins over the bus.
    always_comb begin
        if (nv_ld_en)       src_o = WSRC_NV;
        else if (bus_wr_en) src_o = WSRC_BUS;
        else                src_o = WSRC_NONE;
    end

    // Decode the chosen address into an entry write or a control write.
    always_comb begin
        ent_wr_o   = 1'b0;
        ent_idx_o  = '0;
        ent_data_o = '0;
        ctl_wr_o   = 1'b0;
        ctl_data_o = bus_wdata;
        unique case (src_o)
            WSRC_NV: begin
                ent_wr_o   = (nv_ld_addr < CTL_ADDR);
                ent_idx_o  = nv_ld_addr;
                ent_data_o = nv_ld_data;
            end
            WSRC_BUS: begin
                ent_wr_o   = (bus_addr < CTL_ADDR);
                ent_idx_o  = bus_addr;
                ent_data_o = bus_wdata;
                ctl_wr_o   = (bus_addr == CTL_ADDR);
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/cfg_ctl_reg.sv
// Module: cfg_ctl_reg
// Holds the update-control word (pass-through flag, erase enable).
// Turns a written commit bit into a registered one-cycle commit pulse.
// Gates erase requests with the erase-enable flag.
// The commit bit is never stored, so it reads back as 0.
// Assumes DATA_W >= 3.
module cfg_ctl_reg
    import cfg_dual_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int PAGE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_wr_i,
    input  logic [DATA_W-1:0] ctl_data_i,
    input  logic              erase_req_i,
    input  logic [PAGE_W-1:0] erase_page_i,
    output logic              pass_o,
    output logic              commit_o,
    output logic [DATA_W-1:0] ctl_rd_o,
    output logic              erase_req_o,
    output logic [PAGE_W-1:0] erase_page_o
);
    ctl_state_t state_q;
    logic       commit_q;

    // Store the pass-through and erase-enable flags on a control write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else if (ctl_wr_i) begin
            state_q.pass     <= ctl_data_i[CTL_PASS_BIT];
            state_q.erase_en <= ctl_data_i[CTL_ERASE_BIT];
        end
    end

    // Register a one-cycle commit pulse for a written commit bit.
    always_ff @(posedge clk) begin
        if (!rst_n) commit_q <= 1'b0;
        else        commit_q <= ctl_wr_i && ctl_data_i[CTL_COMMIT_BIT];
    end

    // Build the readback word; the commit bit always reads 0.
    always_comb begin
        ctl_rd_o                = '0;
        ctl_rd_o[CTL_PASS_BIT]  = state_q.pass;
        ctl_rd_o[CTL_ERASE_BIT] = state_q.erase_en;
    end

    assign pass_o       = state_q.pass;
    assign commit_o     = commit_q;
    assign erase_req_o  = erase_req_i && state_q.erase_en;
    assign erase_page_o = erase_page_i;

    AST_COMMIT_FOLLOWS_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr_i && ctl_data_i[CTL_COMMIT_BIT]) |=> commit_o); // R4
    AST_COMMIT_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        commit_o |-> $past(ctl_wr_i)); // R4
    AST_ERASE_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (erase_req_i && !ctl_rd_o[CTL_ERASE_BIT]) |-> !erase_req_o); // R6
endmodule

// File: rtl/cfg_entry.sv
// Module: cfg_entry
// One configuration entry with a front stage (A) and a back stage (B).
// - A write always loads A.
// - In pass-through mode the write also loads B.
// - Otherwise a commit copies the old A into B.
// Assumes the commit strobe is already a single cycle.
module cfg_entry #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic              pass_i,
    input  logic              commit_i,
    input  logic [DATA_W-1:0] data_i,
    output logic [DATA_W-1:0] a_o,
    output logic [DATA_W-1:0] b_o
);
    logic [DATA_W-1:0] a_q;
    logic [DATA_W-1:0] b_q;

    // Front stage: take every write addressed to this entry.
    always_ff @(posedge clk) begin
        if (!rst_n)    a_q <= '0;
        else if (wr_i) a_q <= data_i;
    end

    // Back stage: a pass-through write wins, otherwise commit copies the old A.
    always_ff @(posedge clk) begin
        if (!rst_n)                b_q <= '0;
        else if (wr_i && pass_i)   b_q <= data_i;
        else if (commit_i)         b_q <= a_q;
    end

    assign a_o = a_q;
    assign b_o = b_q;

    AST_PASS_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && pass_i) |=> (b_q == $past(data_i))); // R2
    AST_STAGED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!commit_i && !(wr_i && pass_i)) |=> $stable(b_q)); // R3
    AST_COMMIT_OLD_A: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_i && !(wr_i && pass_i)) |=> (b_q == $past(a_q))); // R5
endmodule

// File: rtl/cfg_dual_bank.sv
// Module: cfg_dual_bank (top)
// A bank of NUM_REGS two-stage configuration entries.
// - The control word sits at address NUM_REGS; higher addresses are unused.
// - cfg_out carries every back stage.
// - bus_rdata returns the front stage or the control word.
module cfg_dual_bank
    import cfg_dual_pkg::*;
#(
    parameter int NUM_REGS = 16,
    parameter int DATA_W   = 8,
    parameter int PAGE_W   = 8,
    localparam int ADDR_W  = $clog2(NUM_REGS + 1),
    localparam int OUT_W   = NUM_REGS * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr_en,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic [ADDR_W-1:0] bus_rd_addr,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              nv_ld_en,
    input  logic [ADDR_W-1:0] nv_ld_addr,
    input  logic [DATA_W-1:0] nv_ld_data,
    input  logic              erase_req_in,
    input  logic [PAGE_W-1:0] erase_page_in,
    output logic              erase_req_out,
    output logic [PAGE_W-1:0] erase_page_out,
    output logic              commit_pulse,
    output logic [OUT_W-1:0]  cfg_out
);
    wr_src_e           src;
    logic              ent_wr;
    logic [ADDR_W-1:0] ent_idx;
    logic [DATA_W-1:0] ent_data;
    logic              ctl_wr;
    logic [DATA_W-1:0] ctl_data;
    logic              pass;
    logic              commit;
    logic [DATA_W-1:0] ctl_rd;
    logic [DATA_W-1:0] a_vals [NUM_REGS];
    logic [DATA_W-1:0] b_vals [NUM_REGS];

    cfg_write_arb #(
        .NUM_REGS (NUM_REGS),
        .DATA_W   (DATA_W),
        .ADDR_W   (ADDR_W)
    ) u_arb (
        .bus_wr_en  (bus_wr_en),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .nv_ld_en   (nv_ld_en),
        .nv_ld_addr (nv_ld_addr),
        .nv_ld_data (nv_ld_data),
        .src_o      (src),
        .ent_wr_o   (ent_wr),
        .ent_idx_o  (ent_idx),
        .ent_data_o (ent_data),
        .ctl_wr_o   (ctl_wr),
        .ctl_data_o (ctl_data)
    );

    cfg_ctl_reg #(
        .DATA_W (DATA_W),
        .PAGE_W (PAGE_W)
    ) u_ctl (
        .clk          (clk),
        .rst_n        (rst_n),
        .ctl_wr_i     (ctl_wr),
        .ctl_data_i   (ctl_data),
        .erase_req_i  (erase_req_in),
        .erase_page_i (erase_page_in),
        .pass_o       (pass),
        .commit_o     (commit),
        .ctl_rd_o     (ctl_rd),
        .erase_req_o  (erase_req_out),
        .erase_page_o (erase_page_out)
    );

    for (genvar gi = 0; gi < NUM_REGS; gi++) begin : g_entry
        cfg_entry #(
            .DATA_W (DATA_W)
        ) u_entry (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_i     (ent_wr && (ent_idx == ADDR_W'(gi))),
            .pass_i   (pass),
            .commit_i (commit),
            .data_i   (ent_data),
            .a_o      (a_vals[gi]),
            .b_o      (b_vals[gi])
        );
        assign cfg_out[gi*DATA_W +: DATA_W] = b_vals[gi];
    end

    // Readback mux: front stage, control word, or zero for unused addresses.
    always_comb begin
        bus_rdata = '0;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (bus_rd_addr == ADDR_W'(i)) bus_rdata = a_vals[i];
        end
        if (bus_rd_addr == ADDR_W'(NUM_REGS)) bus_rdata = ctl_rd;
    end

    assign commit_pulse = commit;

    AST_NV_PRIORITY: assert property (@(posedge clk) disable iff (!rst_n)
        nv_ld_en |-> (src == WSRC_NV) && !ctl_wr); // R8
    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_pulse && !$past(ctl_wr)) |-> 1'b0); // R4
endmodule

// File: tb/sim_cfg_dual_bank.sv
module sim_cfg_dual_bank;
    localparam int N  = 16;
    localparam int DW = 8;
    localparam int PW = 8;
    localparam int AW = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_wr_en = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [DW-1:0] bus_wdata = '0;
    logic [AW-1:0] bus_rd_addr = '0;
    logic [DW-1:0] bus_rdata;
    logic          nv_ld_en = 1'b0;
    logic [AW-1:0] nv_ld_addr = '0;
    logic [DW-1:0] nv_ld_data = '0;
    logic          erase_req_in = 1'b0;
    logic [PW-1:0] erase_page_in = '0;
    logic          erase_req_out;
    logic [PW-1:0] erase_page_out;
    logic          commit_pulse;
    logic [N*DW-1:0] cfg_out;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    logic [DW-1:0] mA [N];
    logic [DW-1:0] mB [N];
    logic mPass = 0, mErase = 0, mPend = 0;

    always #5 clk = ~clk;

    cfg_dual_bank #(.NUM_REGS(N), .DATA_W(DW), .PAGE_W(PW)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_wr_en(bus_wr_en), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rd_addr(bus_rd_addr), .bus_rdata(bus_rdata),
        .nv_ld_en(nv_ld_en), .nv_ld_addr(nv_ld_addr), .nv_ld_data(nv_ld_data),
        .erase_req_in(erase_req_in), .erase_page_in(erase_page_in),
        .erase_req_out(erase_req_out), .erase_page_out(erase_page_out),
        .commit_pulse(commit_pulse), .cfg_out(cfg_out)
    );

    task automatic chk(input string tag, input logic [N*DW-1:0] act, input logic [N*DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [N*DW-1:0] exp_out();
        logic [N*DW-1:0] v;
        for (int i = 0; i < N; i++) v[i*DW +: DW] = mB[i];
        return v;
    endfunction

    function automatic logic [DW-1:0] exp_rd(input logic [AW-1:0] ra);
        if (ra < AW'(N)) return mA[ra[3:0]];
        if (ra == AW'(N)) return {5'b0, mErase, 1'b0, mPass};
        return '0;
    endfunction

    // Model one clock edge from the requirements: commit copies old A,
    // then the selected write lands (reload first, bus otherwise).
    task automatic model_edge(input logic be, input logic [AW-1:0] ba, input logic [DW-1:0] bd,
                              input logic ne, input logic [AW-1:0] na, input logic [DW-1:0] nd);
        logic [DW-1:0] oldA [N];
        logic          oldPass;
        logic          newPend;
        oldPass = mPass;
        newPend = 0;
        for (int i = 0; i < N; i++) oldA[i] = mA[i];
        if (mPend) for (int i = 0; i < N; i++) mB[i] = oldA[i];
        if (ne) begin
            if (na < AW'(N)) begin
                mA[na[3:0]] = nd;
                if (oldPass) mB[na[3:0]] = nd;
            end
        end else if (be) begin
            if (ba < AW'(N)) begin
                mA[ba[3:0]] = bd;
                if (oldPass) mB[ba[3:0]] = bd;
            end else if (ba == AW'(N)) begin
                mPass   = bd[0];
                mErase  = bd[2];
                newPend = bd[1];
            end
        end
        mPend = newPend;
    endtask

    task automatic cyc(input string tag, input logic be, input logic [AW-1:0] ba, input logic [DW-1:0] bd,
                       input logic ne, input logic [AW-1:0] na, input logic [DW-1:0] nd,
                       input logic ei, input logic [PW-1:0] ep, input logic [AW-1:0] ra);
        @(negedge clk);
        bus_wr_en = be; bus_addr = ba; bus_wdata = bd;
        nv_ld_en = ne; nv_ld_addr = na; nv_ld_data = nd;
        erase_req_in = ei; erase_page_in = ep; bus_rd_addr = ra;
        @(posedge clk);
        model_edge(be, ba, bd, ne, na, nd);
        #1;
        chk({tag, " cfg_out"}, cfg_out, exp_out());
        chk({tag, " commit"}, (N*DW)'(commit_pulse), (N*DW)'(mPend));
        chk({tag, " rdata"}, (N*DW)'(bus_rdata), (N*DW)'(exp_rd(ra)));
        chk({tag, " erase R6"}, (N*DW)'({erase_req_out, erase_page_out}), (N*DW)'({ei & mErase, ep}));
    endtask

    task automatic bus_w(input string tag, input logic [AW-1:0] a, input logic [DW-1:0] d, input logic [AW-1:0] ra);
        cyc(tag, 1'b1, a, d, 1'b0, '0, '0, 1'b0, '0, ra);
    endtask

    task automatic idle(input string tag, input logic [AW-1:0] ra);
        cyc(tag, 1'b0, '0, '0, 1'b0, '0, '0, 1'b0, '0, ra);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        finish_run();
    end

    initial begin
        for (int i = 0; i < N; i++) begin mA[i] = '0; mB[i] = '0; end
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        #1;
        chk("R1 reset cfg_out", cfg_out, '0);
        chk("R1 reset commit", (N*DW)'(commit_pulse), '0);
        @(negedge clk); bus_rd_addr = AW'(N); #1;
        chk("R1 reset ctl", (N*DW)'(bus_rdata), '0);
        rst_n = 1'b1;

        // Pass-through write.
        bus_w("R10 ctl", AW'(N), 8'h01, AW'(N));
        chk("R10 ctl readback", (N*DW)'(bus_rdata), (N*DW)'(8'h01));
        bus_w("R2 pass", 5'd3, 8'hA5, 5'd3);
        chk("R2 entry3", (N*DW)'(cfg_out[3*DW +: DW]), (N*DW)'(8'hA5));

        // Staged write then commit.
        bus_w("R3 ctl", AW'(N), 8'h00, AW'(N));
        bus_w("R3 staged", 5'd5, 8'h3C, 5'd5);
        chk("R3 out5 held", (N*DW)'(cfg_out[5*DW +: DW]), '0);
        chk("R3 readback", (N*DW)'(bus_rdata), (N*DW)'(8'h3C));
        bus_w("R4 cmd", AW'(N), 8'h02, AW'(N));
        chk("R4 pulse high", (N*DW)'(commit_pulse), 1);
        chk("R10 bit1 reads 0", (N*DW)'(bus_rdata), '0);
        idle("R4 pulse cycle", 5'd5);
        chk("R4 committed", (N*DW)'(cfg_out[5*DW +: DW]), (N*DW)'(8'h3C));
        chk("R4 pulse low", (N*DW)'(commit_pulse), 0);

        // Staged write colliding with commit pulse.
        bus_w("R5 pre", 5'd6, 8'h11, 5'd6);
        bus_w("R5 cmd", AW'(N), 8'h02, 5'd6);
        bus_w("R5 collide", 5'd6, 8'h22, 5'd6);
        chk("R5 old A committed", (N*DW)'(cfg_out[6*DW +: DW]), (N*DW)'(8'h11));
        chk("R5 new A kept", (N*DW)'(bus_rdata), (N*DW)'(8'h22));
        bus_w("R5 cmd2", AW'(N), 8'h02, 5'd6);
        idle("R5 pulse2", 5'd6);
        chk("R5 second commit", (N*DW)'(cfg_out[6*DW +: DW]), (N*DW)'(8'h22));

        // Erase gating.
        cyc("R6 blocked", 1'b0, '0, '0, 1'b0, '0, '0, 1'b1, 8'h4D, 5'd0);
        chk("R6 blocked out", (N*DW)'(erase_req_out), 0);
        bus_w("R6 enable", AW'(N), 8'h04, AW'(N));
        cyc("R6 allowed", 1'b0, '0, '0, 1'b0, '0, '0, 1'b1, 8'h4D, 5'd0);
        chk("R6 allowed out", (N*DW)'({erase_req_out, erase_page_out}), (N*DW)'({1'b1, 8'h4D}));

        // Reload staged.
        cyc("R7 reload", 1'b0, '0, '0, 1'b1, 5'd7, 8'h5A, 1'b0, '0, 5'd7);
        chk("R7 out7 held", (N*DW)'(cfg_out[7*DW +: DW]), '0);
        chk("R7 A7", (N*DW)'(bus_rdata), (N*DW)'(8'h5A));

        // Reload and bus collide.
        cyc("R8 same entry", 1'b1, 5'd8, 8'hFF, 1'b1, 5'd8, 8'h01, 1'b0, '0, 5'd8);
        chk("R8 reload wins", (N*DW)'(bus_rdata), (N*DW)'(8'h01));
        cyc("R8 ctl dropped", 1'b1, AW'(N), 8'h01, 1'b1, 5'd9, 8'h09, 1'b0, '0, AW'(N));
        chk("R8 ctl unchanged", (N*DW)'(bus_rdata), (N*DW)'(8'h04));

        // Unused addresses.
        bus_w("R9 unused", 5'd20, 8'hEE, 5'd20);
        chk("R9 rd unused", (N*DW)'(bus_rdata), '0);
        cyc("R9 reload ctl addr", 1'b0, '0, '0, 1'b1, AW'(N), 8'h03, 1'b0, '0, AW'(N));
        chk("R9 ctl intact", (N*DW)'(bus_rdata), (N*DW)'(8'h04));

        // Random mix.
        for (int k = 0; k < 3000; k++) begin
            logic [AW-1:0] ba, na, ra;
            ba = AW'($urandom_range(0, 19));
            na = AW'($urandom_range(0, 17));
            ra = AW'($urandom_range(0, 19));
            cyc("rand R2 R3 R4 R5 R7 R8 R9 R10",
                1'($urandom_range(0, 1)), ba, 8'($urandom),
                ($urandom_range(0, 3) == 0), na, 8'($urandom),
                1'($urandom_range(0, 1)), 8'($urandom), ra);
        end
        finish_run();
    end
endmodule